// File: doc/BRIEF.md
# Nibble Register File with Status Skip

This block holds the programmer-visible state of a small 4-bit controller core: an accumulator, a sub-accumulator, two RAM-addressing registers with a shadow stack register each, a carry flag and a status flag. Each cycle it accepts one command from the sequencer, an ALU result nibble with its overflow bit, and a status bit. It then updates exactly the state that the command names.

The status flag gates conditional instructions such as page loads, branches and calls. While the sequencer presents a conditional command, the block reports in the same cycle whether that instruction executes. A cleared status flag makes the instruction a skip, and the skip sets the flag back to 1. The ALU, the decoder, the program counter and the RAM stay outside the block and reach it only through the input ports.

Top module: `nib_regfile`

## Requirements
- R1: While `rst_n` is 0 at a clock edge, every register and the carry become 0 and the status becomes 1.
- R2: Command 1 loads `alu_res_i` into A and `alu_ovf_i` into carry at the same edge.
- R3: Commands 2, 3 and 4 load `alu_res_i` into B, X and Y respectively. No other register or flag changes.
- R4: Command 9 sets carry to 1 and command 10 clears it. A and the status stay unchanged.
- R5: Command 11 copies the carry into the status flag. The carry itself stays unchanged.
- R6: Command 7 rotates the 5-bit chain {A, carry} left by one place: A[3] goes to carry, carry goes to A[0], and A[2:0] shift up.
- R7: Command 8 rotates the chain right by one place: A[0] goes to carry, carry goes to A[3], and A[3:1] shift down.
- R8: Command 5 swaps X with SPX and command 6 swaps Y with SPY in a single edge. The stack registers change by no other command.
- R9: Command 12 loads `st_i` into the status flag.
- R10: While command 13 (conditional) is present, `exec_o` equals the status flag and is 0 for every other command. A conditional command with status 0 sets status to 1, and with status 1 it leaves status at 1.
- R11: Command 0 and the unused codes 14 and 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 4 | Command code for this cycle |
| alu_res_i | input | 4 | ALU result nibble |
| alu_ovf_i | input | 1 | ALU overflow bit |
| st_i | input | 1 | Status source (not-zero, overflow or bit test) |
| a_o | output | 4 | Accumulator |
| b_o | output | 4 | B register |
| x_o | output | 4 | X register |
| spx_o | output | 4 | X stack register |
| y_o | output | 4 | Y register |
| spy_o | output | 4 | Y stack register |
| c_o | output | 1 | Carry flag |
| s_o | output | 1 | Status flag |
| exec_o | output | 1 | 1 when the present conditional command executes |

## Verification
The bench targets rotations whose carry-in differs from the bit that leaves the chain. A design that rotated only A, or that turned the chain the wrong way, would leave the wrong bit in carry or in an end bit of A. It runs back-to-back swaps, where a design that copied instead of swapping would duplicate one value into both registers. It also runs a conditional command with status 0 followed by a second conditional command: a design that forgot to restore the status would skip both, and one that reported the flag after restoring it would execute the first. Long random command streams catch any command that touches state outside its own target.

// File: rtl/nib_pkg.sv
// Shared command codes and widths for the nibble register file.
// Assumes one command per cycle, chosen by the instruction sequencer.
package nib_pkg;
    localparam int NIB_W = 4;
    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'd0,
        CMD_WR_A   = 4'd1,
        CMD_WR_B   = 4'd2,
        CMD_WR_X   = 4'd3,
        CMD_WR_Y   = 4'd4,
        CMD_XCH_X  = 4'd5,
        CMD_XCH_Y  = 4'd6,
        CMD_ROT_L  = 4'd7,
        CMD_ROT_R  = 4'd8,
        CMD_C_SET  = 4'd9,
        CMD_C_CLR  = 4'd10,
        CMD_C_TEST = 4'd11,
        CMD_ST_LD  = 4'd12,
        CMD_COND   = 4'd13
    } nib_cmd_e;
endpackage

// File: rtl/nib_acc_unit.sv
// Accumulator and carry flag. Loads ALU result and overflow, rotates the
// {A, carry} chain either way, and sets or clears carry on command.
// Assumes: cmd is a valid command code or an unused code, which holds state.
module nib_acc_unit
    import nib_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  nib_cmd_e     cmd,
    input  logic [W-1:0] res,
    input  logic         ovf,
    output logic [W-1:0] a_q,
    output logic         c_q
);
    // Update accumulator and carry according to the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            c_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_WR_A:  begin a_q <= res; c_q <= ovf; end
                CMD_ROT_L: {c_q, a_q} <= {a_q, c_q};
                CMD_ROT_R: {c_q, a_q} <= {a_q[0], c_q, a_q[W-1:1]};
                CMD_C_SET: c_q <= 1'b1;
                CMD_C_CLR: c_q <= 1'b0;
                default:   ;
            endcase
        end
    end

    // R1
    acc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (a_q == '0 && !c_q));
    // R2
    acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_WR_A |=> (a_q == $past(res) && c_q == $past(ovf)));
    // R6
    rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ROT_L |=> (c_q == $past(a_q[W-1]) && a_q[0] == $past(c_q)));
    // R7
    rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ROT_R |=> (c_q == $past(a_q[0]) && a_q[W-1] == $past(c_q)));
    // R4
    carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_C_SET |=> (c_q && $stable(a_q)));
endmodule

// File: rtl/nib_stack_pair.sv
// One working register with a shadow stack register. The working register
// loads the ALU result on its load command; the exchange command swaps the
// two in one edge. The stack register changes only on exchange.
// Assumes: load and exchange codes differ.
module nib_stack_pair
    import nib_pkg::*;
#(
    parameter int       W       = NIB_W,
    parameter nib_cmd_e LOAD_OP = CMD_WR_X,
    parameter nib_cmd_e XCH_OP  = CMD_XCH_X
) (
    input  logic         clk,
    input  logic         rst_n,
    input  nib_cmd_e     cmd,
    input  logic [W-1:0] res,
    output logic [W-1:0] work_q,
    output logic [W-1:0] stk_q
);
    // Load or swap the pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            stk_q  <= '0;
        end else if (cmd == XCH_OP) begin
            work_q <= stk_q;
            stk_q  <= work_q;
        end else if (cmd == LOAD_OP) begin
            work_q <= res;
        end
    end

    // R8
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == XCH_OP |=> (work_q == $past(stk_q) && stk_q == $past(work_q)));
    // R8
    stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != XCH_OP |=> $stable(stk_q));
    // R3
    work_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == LOAD_OP |=> work_q == $past(res));
endmodule

// File: rtl/nib_status_unit.sv
// Status flag and conditional-execute decision. Status loads from the
// status source or from carry. A conditional command executes only with
// status 1; with status 0 it is skipped and status returns to 1.
// Assumes: exec_o is used by the sequencer in the cycle the command is held.
module nib_status_unit
    import nib_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  nib_cmd_e cmd,
    input  logic     carry,
    input  logic     st_src,
    output logic     s_q,
    output logic     exec_o
);
    logic is_cond;

    // Decode the conditional command
    always_comb is_cond = (cmd == CMD_COND);

    // Execute decision follows the held status
    always_comb exec_o = is_cond && s_q;

    // Update status flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= 1'b1;
        end else begin
            case (cmd)
                CMD_ST_LD:  s_q <= st_src;
                CMD_C_TEST: s_q <= carry;
                CMD_COND:   s_q <= 1'b1;
                default:    ;
            endcase
        end
    end

    // R1
    status_reset_chk: assert property (@(posedge clk) !rst_n |=> s_q);
    // R10
    skip_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cond && !exec_o) |=> s_q);
    // R10
    exec_only_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cond |-> !exec_o);
    // R5
    ctest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_C_TEST |=> s_q == $past(carry));
    // R9
    stload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ST_LD |=> s_q == $past(st_src));
endmodule

// File: rtl/nib_regfile.sv
// Top of the nibble register file: accumulator/carry, B register, the X and
// Y pairs with their stack registers, and the status/skip logic.
// Assumes: one command per cycle; ALU result and status source are valid
// with the command.
module nib_regfile
    import nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [NIB_W-1:0] alu_res_i,
    input  logic             alu_ovf_i,
    input  logic             st_i,
    output logic [NIB_W-1:0] a_o,
    output logic [NIB_W-1:0] b_o,
    output logic [NIB_W-1:0] x_o,
    output logic [NIB_W-1:0] spx_o,
    output logic [NIB_W-1:0] y_o,
    output logic [NIB_W-1:0] spy_o,
    output logic             c_o,
    output logic             s_o,
    output logic             exec_o
);
    localparam int PAIRS = 2;
    localparam nib_cmd_e LOAD_CODES [PAIRS] = '{CMD_WR_X, CMD_WR_Y};
    localparam nib_cmd_e XCH_CODES  [PAIRS] = '{CMD_XCH_X, CMD_XCH_Y};

    nib_cmd_e         cmd_e;
    logic [NIB_W-1:0] work_w [PAIRS];
    logic [NIB_W-1:0] stk_w  [PAIRS];
    logic [NIB_W-1:0] b_q;

    // Interpret the raw command bits
    always_comb cmd_e = nib_cmd_e'(cmd_i);

    nib_acc_unit #(.W(NIB_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_e),
        .res(alu_res_i), .ovf(alu_ovf_i),
        .a_q(a_o), .c_q(c_o)
    );

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        nib_stack_pair #(
            .W(NIB_W), .LOAD_OP(LOAD_CODES[p]), .XCH_OP(XCH_CODES[p])
        ) u_pair (
            .clk(clk), .rst_n(rst_n), .cmd(cmd_e), .res(alu_res_i),
            .work_q(work_w[p]), .stk_q(stk_w[p])
        );
    end

    nib_status_unit u_stat (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_e), .carry(c_o),
        .st_src(st_i), .s_q(s_o), .exec_o(exec_o)
    );

    // B register: sub-accumulator loaded from the ALU result
    always_ff @(posedge clk) begin
        if (!rst_n)                b_q <= '0;
        else if (cmd_e == CMD_WR_B) b_q <= alu_res_i;
    end

    // Route pair outputs to named ports
    always_comb begin
        b_o   = b_q;
        x_o   = work_w[0];
        spx_o = stk_w[0];
        y_o   = work_w[1];
        spy_o = stk_w[1];
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd0 || cmd_i == 4'd14 || cmd_i == 4'd15) |=>
        ($stable(a_o) && $stable(b_o) && $stable(x_o) && $stable(y_o) &&
         $stable(c_o) && $stable(s_o)));
    // R3
    b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_e == CMD_WR_B |=> (b_o == $past(alu_res_i) && $stable(a_o)));
endmodule

// File: tb/sim_nib_regfile.sv
module sim_nib_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd_i = 4'd0;
    logic [3:0] alu_res_i = 4'd0;
    logic       alu_ovf_i = 1'b0;
    logic       st_i = 1'b0;
    logic [3:0] a_o, b_o, x_o, spx_o, y_o, spy_o;
    logic       c_o, s_o, exec_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] m_a, m_b, m_x, m_spx, m_y, m_spy;
    logic       m_c, m_s;

    always #10 clk = ~clk;

    nib_regfile u0 (.*);

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R8";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9, 4'd10: return "R4";
            4'd11: return "R5";
            4'd12: return "R9";
            4'd13: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "A", a_o, m_a);
        check(req, "B", b_o, m_b);
        check(req, "X", x_o, m_x);
        check(req, "SPX", spx_o, m_spx);
        check(req, "Y", y_o, m_y);
        check(req, "SPY", spy_o, m_spy);
        check(req, "C", {3'b0, c_o}, {3'b0, m_c});
        check(req, "S", {3'b0, s_o}, {3'b0, m_s});
    endtask

    // Reference next-state model
    task automatic model_step(input logic [3:0] c, input logic [3:0] r,
                              input logic o, input logic st);
        logic [3:0] t;
        case (c)
            4'd1: begin m_a = r; m_c = o; end
            4'd2: m_b = r;
            4'd3: m_x = r;
            4'd4: m_y = r;
            4'd5: begin t = m_x; m_x = m_spx; m_spx = t; end
            4'd6: begin t = m_y; m_y = m_spy; m_spy = t; end
            4'd7: begin t = m_a; m_a = {t[2:0], m_c}; m_c = t[3]; end
            4'd8: begin t = m_a; m_a = {m_c, t[3:1]}; m_c = t[0]; end
            4'd9: m_c = 1'b1;
            4'd10: m_c = 1'b0;
            4'd11: m_s = m_c;
            4'd12: m_s = st;
            4'd13: m_s = 1'b1;
            default: ;
        endcase
    endtask

    // Drive one command, check exec before the edge, check state after it
    task automatic step(input logic [3:0] c, input logic [3:0] r,
                        input logic o, input logic st);
        string rq;
        rq = req_of(c);
        cmd_i = c; alu_res_i = r; alu_ovf_i = o; st_i = st;
        #1;
        check("R10", "exec", {3'b0, exec_o}, {3'b0, (c == 4'd13) && m_s});
        model_step(c, r, o, st);
        @(negedge clk);
        check_all(rq);
    endtask

    initial begin
        void'($urandom(32'd4711));
        m_a = 0; m_b = 0; m_x = 0; m_spx = 0; m_y = 0; m_spy = 0;
        m_c = 0; m_s = 1;
        cmd_i = 4'd2; alu_res_i = 4'hF;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // R6 / R7 directed rotations with differing carry-in
        step(4'd1, 4'b1000, 1'b1, 1'b0);
        step(4'd7, 4'h0, 1'b0, 1'b0);
        step(4'd7, 4'h0, 1'b0, 1'b0);
        step(4'd1, 4'b0001, 1'b0, 1'b0);
        step(4'd8, 4'h0, 1'b0, 1'b0);
        step(4'd8, 4'h0, 1'b0, 1'b0);
        // R8 back-to-back swaps
        step(4'd3, 4'hA, 1'b0, 1'b0);
        step(4'd5, 4'h0, 1'b0, 1'b0);
        step(4'd3, 4'h5, 1'b0, 1'b0);
        step(4'd5, 4'h0, 1'b0, 1'b0);
        step(4'd5, 4'h0, 1'b0, 1'b0);
        step(4'd4, 4'h3, 1'b0, 1'b0);
        step(4'd6, 4'h0, 1'b0, 1'b0);
        // R10 skip then execute
        step(4'd12, 4'h0, 1'b0, 1'b0);
        step(4'd13, 4'h0, 1'b0, 1'b0);
        step(4'd13, 4'h0, 1'b0, 1'b0);
        // R5 carry test into status, R4 carry commands
        step(4'd10, 4'h0, 1'b0, 1'b1);
        step(4'd11, 4'h0, 1'b0, 1'b1);
        step(4'd13, 4'h0, 1'b0, 1'b0);
        step(4'd9, 4'h0, 1'b0, 1'b0);
        step(4'd11, 4'h0, 1'b0, 1'b0);
        // R11 idle codes
        step(4'd14, 4'h7, 1'b1, 1'b0);
        step(4'd15, 4'h7, 1'b1, 1'b0);
        step(4'd0, 4'h7, 1'b1, 1'b0);

        // Random stream
        for (int i = 0; i < 3000; i++) begin
            step(4'($urandom % 16), 4'($urandom % 16),
                 1'($urandom % 2), 1'($urandom % 2));
        end

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        m_a = 0; m_b = 0; m_x = 0; m_spx = 0; m_y = 0; m_spy = 0;
        m_c = 0; m_s = 1;
        check_all("R1");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule